// File: doc/BRIEF.md
# Pulse-Triggered I/Q Waveform Capture

This block records short windows of complex baseband data inside a pulsed RF controller so that software can read them back between pulses. It has several independent capture channels. Each channel stores 512 entries, and each entry holds a 16-bit in-phase word and a 16-bit quadrature word. Each channel takes its samples from one of several internal I/Q sources, chosen by a per-channel selector.

Software arms a channel and gives it three settings: a source, a decimation exponent `z` (one sample kept every 2^z clocks) and a start delay in clock cycles. The channel then waits for the next rising edge of the RF gate. It skips the delay, writes 512 decimated samples and freezes. The frozen contents can be read through a registered address/data port, and they stay unchanged until software arms that channel again.

Each channel is a five-state sequencer: idle, armed, delaying, capturing, done. Each sequencer drives its own single-port-write storage bank. A shared read multiplexer picks the bank named by the read channel number.

Top module: `wfm_capture`

## Requirements
- R1: While reset is high, every done flag is 0 and `rd_i`/`rd_q` read 0.
- R2: An arm pulse is accepted only in idle or done. On the accepting clock edge the channel latches `sel_cfg`, `zoom_cfg` and `pan_cfg` and clears its done flag. Changes to these inputs after that edge have no effect on the capture.
- R3: An armed channel starts only on a gate edge: a clock edge where `rf_gate` is 1 after it was 0 at the previous edge. A gate that is already high when the channel is armed does not start a capture.
- R4: If the trigger edge is E and the latched delay is P (0 to 65535), the first stored sample (address 0) is the source value present at edge E+1+P.
- R5: With latched exponent z (0 to 7), the sample at address n is the source value present at edge E+1+P+n·2^z, for n from 0 to 511.
- R6: Selector value s picks source s. Its I word is `src_i_bus[16s+15:16s]` and its Q word is `src_q_bus[16s+15:16s]`.
- R7: A channel's done flag rises on the edge that writes address 511. It stays high until that channel is armed again.
- R8: An arm pulse is ignored while the channel is armed, delaying or capturing. The latched settings and the running capture are unaffected.
- R9: In done, further gate edges do not write the buffer. Its contents stay frozen.
- R10: `rd_ch` and `rd_addr` are sampled at a clock edge. `rd_i`/`rd_q` show that channel's stored entry after the same edge.
- R11: Once started, a capture runs to completion whatever the gate level does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rf_gate | input | 1 | RF pulse gate; a rising edge triggers armed channels |
| src_i_bus | input | 64 | In-phase words of the 4 sources, source s at bits [16s+15:16s] |
| src_q_bus | input | 64 | Quadrature words of the 4 sources, same packing |
| arm | input | 5 | One arm pulse bit per channel |
| sel_cfg | input | 10 | Source selector per channel, 2 bits each |
| zoom_cfg | input | 15 | Decimation exponent per channel, 3 bits each |
| pan_cfg | input | 80 | Start delay in cycles per channel, 16 bits each |
| rd_ch | input | 3 | Channel to read |
| rd_addr | input | 9 | Entry to read |
| rd_i | output | 16 | In-phase word read |
| rd_q | output | 16 | Quadrature word read |
| done | output | 5 | Per-channel capture complete flag |

## Verification
The bench runs four channels at once from a single gate pulse. They use the smallest and largest decimation, zero and large delays, and different sources. Every stored entry is compared with the source value expected at its exact edge. A one-cycle error in the delay or decimation count would therefore shift every entry, and a wrong source slice would return another source's words.

The gate is dropped a few cycles after the trigger, so a sequencer that followed the gate level would stop early. Arm pulses and settings changes are issued in the middle of captures; a design that accepted them would restart or re-decimate and fail the readback. A second gate pulse while a channel is done checks that the frozen buffer is not overwritten.

Two channels are then armed while the gate is already high. A design that triggered on level rather than edge would raise done before the real edge. The done edge of the fastest channel is checked at its exact cycle.

// File: rtl/wfm_pkg.sv
package wfm_pkg;

    localparam int SAMPLE_W = 16;

    typedef struct packed {
        logic [SAMPLE_W-1:0] i;
        logic [SAMPLE_W-1:0] q;
    } iq_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_DELAY = 3'd2,
        ST_CAPT  = 3'd3,
        ST_DONE  = 3'd4
    } cap_state_e;

    // an arm request is honoured only when the channel is at rest
    function automatic logic arm_allowed(cap_state_e s);
        return (s == ST_IDLE) || (s == ST_DONE);
    endfunction

    function automatic logic in_flight(cap_state_e s);
        return (s == ST_ARMED) || (s == ST_DELAY) || (s == ST_CAPT);
    endfunction

endpackage

// File: rtl/wfm_chan_seq.sv
module wfm_chan_seq
    import wfm_pkg::*;
#(
    parameter int NSRC  = 4,
    parameter int ZW    = 3,
    parameter int PW    = 16,
    parameter int DEPTH = 512,
    parameter int SW    = (NSRC > 1) ? $clog2(NSRC) : 1,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             trig,
    input  logic [SW-1:0]    sel_in,
    input  logic [ZW-1:0]    zoom_in,
    input  logic [PW-1:0]    pan_in,
    input  iq_t  [NSRC-1:0]  srcs,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output iq_t              wdata,
    output logic             done
);
    // decimation counter wide enough for 2^(2^ZW - 1) - 1
    localparam int CW = (1 << ZW) - 1;
    localparam logic [CW-1:0] CNT_ONES = '1;
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    cap_state_e    st;
    logic [SW-1:0] sel_q;
    logic [ZW-1:0] zoom_q;
    logic [PW-1:0] pan_q;
    logic [PW-1:0] dly;
    logic [CW-1:0] dcnt;

    assign we    = (st == ST_CAPT) && (dcnt == '0);
    assign wdata = (int'(sel_q) < NSRC) ? srcs[sel_q] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            sel_q  <= '0;
            zoom_q <= '0;
            pan_q  <= '0;
            dly    <= '0;
            dcnt   <= '0;
            waddr  <= '0;
            done   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE, ST_DONE: begin
                    if (arm) begin
                        st     <= ST_ARMED;
                        sel_q  <= sel_in;
                        zoom_q <= zoom_in;
                        pan_q  <= pan_in;
                        done   <= 1'b0;
                    end
                end
                ST_ARMED: begin
                    if (trig) begin
                        waddr <= '0;
                        dcnt  <= '0;
                        dly   <= pan_q;
                        st    <= (pan_q == '0) ? ST_CAPT : ST_DELAY;
                    end
                end
                ST_DELAY: begin
                    if (dly == PW'(1)) st <= ST_CAPT;
                    else               dly <= dly - 1'b1;
                end
                ST_CAPT: begin
                    if (dcnt == '0) begin
                        // reload with 2^z - 1 : z low ones
                        dcnt  <= ~(CNT_ONES << zoom_q);
                        waddr <= waddr + 1'b1;
                        if (waddr == LAST_ADDR) begin
                            st   <= ST_DONE;
                            done <= 1'b1;
                        end
                    end else begin
                        dcnt <= dcnt - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_ARMED && st != ST_ARMED) |-> $past(trig)); // R3

    AST_ARM_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (arm && in_flight(st)) |=> ($stable(zoom_q) && $stable(pan_q) && $stable(sel_q))); // R8

    AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(we) && $past(waddr) == LAST_ADDR)); // R7

    AST_DECIM_GAP: assert property (@(posedge clk) disable iff (rst)
        (we && zoom_q != '0) |=> !we); // R5

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (arm && done) |=> !done); // R2

    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        done |-> !we); // R9

endmodule

// File: rtl/wfm_bank.sv
module wfm_bank
    import wfm_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  iq_t           wdata,
    input  logic [AW-1:0] raddr,
    output iq_t           rdata
);
    iq_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= mem[raddr];
    end

endmodule

// File: rtl/wfm_capture.sv
module wfm_capture
    import wfm_pkg::*;
#(
    parameter int NCH   = 5,
    parameter int NSRC  = 4,
    parameter int ZW    = 3,
    parameter int PW    = 16,
    parameter int DEPTH = 512,
    parameter int SW    = (NSRC > 1) ? $clog2(NSRC) : 1,
    parameter int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rf_gate,
    input  logic [NSRC*SAMPLE_W-1:0] src_i_bus,
    input  logic [NSRC*SAMPLE_W-1:0] src_q_bus,
    input  logic [NCH-1:0]           arm,
    input  logic [NCH*SW-1:0]        sel_cfg,
    input  logic [NCH*ZW-1:0]        zoom_cfg,
    input  logic [NCH*PW-1:0]        pan_cfg,
    input  logic [CHW-1:0]           rd_ch,
    input  logic [AW-1:0]            rd_addr,
    output logic [SAMPLE_W-1:0]      rd_i,
    output logic [SAMPLE_W-1:0]      rd_q,
    output logic [NCH-1:0]           done
);
    iq_t [NSRC-1:0] srcs;
    iq_t            rdata [NCH];
    iq_t            rsel;
    logic           gate_q;
    logic           trig;
    logic [CHW-1:0] rch_q;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign srcs[s].i = src_i_bus[s*SAMPLE_W +: SAMPLE_W];
        assign srcs[s].q = src_q_bus[s*SAMPLE_W +: SAMPLE_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            rch_q  <= '0;
        end else begin
            gate_q <= rf_gate;
            rch_q  <= rd_ch;
        end
    end

    assign trig = rf_gate && !gate_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic          we;
        logic [AW-1:0] waddr;
        iq_t           wdata;

        wfm_chan_seq #(
            .NSRC(NSRC), .ZW(ZW), .PW(PW), .DEPTH(DEPTH), .SW(SW), .AW(AW)
        ) u_seq (
            .clk     (clk),
            .rst     (rst),
            .arm     (arm[c]),
            .trig    (trig),
            .sel_in  (sel_cfg[c*SW +: SW]),
            .zoom_in (zoom_cfg[c*ZW +: ZW]),
            .pan_in  (pan_cfg[c*PW +: PW]),
            .srcs    (srcs),
            .we      (we),
            .waddr   (waddr),
            .wdata   (wdata),
            .done    (done[c])
        );

        wfm_bank #(
            .DEPTH(DEPTH), .AW(AW)
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (we),
            .waddr (waddr),
            .wdata (wdata),
            .raddr (rd_addr),
            .rdata (rdata[c])
        );
    end

    always_comb begin
        rsel = '0;
        for (int c = 0; c < NCH; c++) begin
            if (int'(rch_q) == c) rsel = rdata[c];
        end
    end

    assign rd_i = rsel.i;
    assign rd_q = rsel.q;

    AST_RESET_READ: assert property (@(posedge clk)
        rst |=> (rd_i == '0 && rd_q == '0)); // R1

endmodule

// File: tb/sim_wfm_capture.sv
module sim_wfm_capture;
    import wfm_pkg::*;

    localparam int NCH = 5, NSRC = 4, ZW = 3, PW = 16, DEPTH = 512;

    logic               clk = 1'b0;
    logic               rst;
    logic               rf_gate;
    logic [NSRC*16-1:0] src_i_bus, src_q_bus;
    logic [NCH-1:0]     arm;
    logic [NCH*2-1:0]   sel_cfg;
    logic [NCH*ZW-1:0]  zoom_cfg;
    logic [NCH*PW-1:0]  pan_cfg;
    logic [2:0]         rd_ch;
    logic [8:0]         rd_addr;
    logic [15:0]        rd_i, rd_q;
    logic [NCH-1:0]     done;

    int total = 0;
    int bad   = 0;
    int ecnt  = 0;
    logic rd_go = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        int          ch;
        int          addr;
        logic [15:0] i;
        logic [15:0] q;
        string       req;
    } exp_t;
    exp_t sbq[$];

    always #2 clk = ~clk;

    wfm_capture u0 (
        .clk(clk), .rst(rst), .rf_gate(rf_gate),
        .src_i_bus(src_i_bus), .src_q_bus(src_q_bus),
        .arm(arm), .sel_cfg(sel_cfg), .zoom_cfg(zoom_cfg), .pan_cfg(pan_cfg),
        .rd_ch(rd_ch), .rd_addr(rd_addr), .rd_i(rd_i), .rd_q(rd_q), .done(done)
    );

    function automatic logic [15:0] si(int s, int k);
        return 16'(k * 5 + s * 4099 + 3);
    endfunction

    function automatic logic [15:0] sq(int s, int k);
        return 16'((k * 11) ^ (s * 613 + 21));
    endfunction

    always @(posedge clk) ecnt <= ecnt + 1;

    // source value seen at edge k+1 is f(k)
    always @(negedge clk) begin
        for (int s = 0; s < NSRC; s++) begin
            src_i_bus[s*16 +: 16] <= si(s, ecnt);
            src_q_bus[s*16 +: 16] <= sq(s, ecnt);
        end
    end

    // scoreboard monitor: pops expected entries as read data appears (R10)
    always @(posedge clk) begin : mon
        logic go;
        exp_t e;
        go = rd_go;
        #1;
        if (go) begin
            total++;
            if (sbq.size() == 0) begin
                bad++;
                $display("FAIL R10 read with empty scoreboard actual=%h/%h expected=none", rd_i, rd_q);
            end else begin
                e = sbq.pop_front();
                if (rd_i !== e.i || rd_q !== e.q) begin
                    bad++;
                    $display("FAIL %s ch=%0d addr=%0d actual=%h/%h expected=%h/%h",
                             e.req, e.ch, e.addr, rd_i, rd_q, e.i, e.q);
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic arm_ch(input int ch, input int sel, input int z, input int pan);
        @(negedge clk);
        arm[ch] = 1'b1;
        sel_cfg[ch*2 +: 2]    = 2'(sel);
        zoom_cfg[ch*ZW +: ZW] = 3'(z);
        pan_cfg[ch*PW +: PW]  = 16'(pan);
        @(negedge clk);
        arm[ch] = 1'b0;
    endtask

    // driver: expected entry n comes from edge g+2+pan+n*2^z, value f(g+1+pan+n*2^z)
    task automatic push_exp(input int ch, input int sel, input int z, input int pan,
                            input int g, input string req);
        for (int n = 0; n < DEPTH; n++) begin
            int k;
            k = g + 1 + pan + (n << z);
            sbq.push_back('{ch, n, si(sel, k), sq(sel, k), req});
        end
    endtask

    task automatic gate_up(output int g);
        @(negedge clk);
        g = ecnt;
        rf_gate = 1'b1;
    endtask

    task automatic gate_down();
        @(negedge clk);
        rf_gate = 1'b0;
    endtask

    task automatic wait_ecnt(input int t);
        while (ecnt < t) @(negedge clk);
    endtask

    task automatic wait_done(input logic [NCH-1:0] m);
        int c;
        c = 0;
        while ((done & m) != m && c < 150000) begin
            @(negedge clk);
            c++;
        end
        check("R7 completion", 32'(done & m), 32'(m));
    endtask

    task automatic readback(input int ch);
        for (int n = 0; n < DEPTH; n++) begin
            @(negedge clk);
            rd_ch   = 3'(ch);
            rd_addr = 9'(n);
            rd_go   = 1'b1;
        end
        @(negedge clk);
        rd_go = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int g1, g2, g3, w;
        rst = 1'b1; rf_gate = 1'b0; arm = '0;
        sel_cfg = '0; zoom_cfg = '0; pan_cfg = '0;
        rd_ch = '0; rd_addr = '0;
        repeat (5) @(negedge clk);
        check("R1 done", 32'(done), 32'h0);
        check("R1 rd_i", 32'(rd_i), 32'h0);
        check("R1 rd_q", 32'(rd_q), 32'h0);
        rst = 1'b0;

        // four channels, distinct settings (R4 R5 R6)
        arm_ch(0, 0, 0, 0);
        arm_ch(1, 2, 3, 37);
        @(negedge clk);                 // R2: late changes must not matter
        zoom_cfg[1*ZW +: ZW] = 3'd0;
        pan_cfg[1*PW +: PW]  = 16'd2;
        sel_cfg[1*2 +: 2]    = 2'd1;
        arm_ch(2, 3, 7, 5);
        arm_ch(3, 1, 1, 1000);
        check("R2 done clear after arm", 32'(done), 32'h0);

        gate_up(g1);
        repeat (10) @(negedge clk);
        gate_down();                    // R11: gate falls mid-capture
        push_exp(0, 0, 0, 0,    g1, "R4");
        push_exp(1, 2, 3, 37,   g1, "R2");
        push_exp(2, 3, 7, 5,    g1, "R5");
        push_exp(3, 1, 1, 1000, g1, "R6");

        // R7: exact done edge of channel 0
        w = g1 + 2 + 511;
        wait_ecnt(w - 1);
        check("R7 done before last write", 32'(done[0]), 32'h0);
        @(negedge clk);
        check("R7 done after last write", 32'(done[0]), 32'h1);

        // R8: arm attempts while capturing or delaying
        arm_ch(1, 0, 0, 0);
        arm_ch(3, 0, 0, 0);
        // R9: another gate edge while channel 0 is done
        gate_up(g2);
        repeat (4) @(negedge clk);
        gate_down();
        check("R7 done holds", 32'(done[0]), 32'h1);

        wait_done(5'b01111);
        readback(0);
        readback(1);
        readback(2);
        readback(3);
        push_exp(0, 0, 0, 0, g1, "R9");
        readback(0);

        // R3: arming with gate already high must not start
        @(negedge clk);
        rf_gate = 1'b1;
        arm_ch(4, 2, 0, 3);
        arm_ch(0, 1, 2, 0);
        check("R2 rearm clears done", 32'(done[0]), 32'h0);
        repeat (700) @(negedge clk);
        check("R3 no start on level ch4", 32'(done[4]), 32'h0);
        check("R3 no start on level ch0", 32'(done[0]), 32'h0);
        gate_down();
        repeat (3) @(negedge clk);
        gate_up(g3);
        repeat (2) @(negedge clk);
        gate_down();
        push_exp(0, 1, 2, 0, g3, "R3");
        push_exp(4, 2, 0, 3, g3, "R4");
        wait_done(5'b10001);
        readback(0);
        readback(4);
        check("R10 scoreboard drained", 32'(sbq.size()), 32'h0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule